// File: doc/BRIEF.md
# Sixteen-Bit Two-Level Lookahead Adder

This block adds two 16-bit operands and a carry-in in a single combinational pass. It returns a 16-bit sum and a carry-out. No carry travels bit by bit across the word. The operands are split into four 4-bit groups. Each group works out, for every bit, whether that bit creates a carry (both inputs set) or can pass one on (either input set). From these it forms a group-wide create flag and a group-wide pass flag. A second lookahead stage takes the four group flag pairs and the carry-in and computes, in expanded sum-of-products form, the carry entering each group and the final carry-out. Inside a group, the carries into bits 1 to 3 come from the same kind of expanded equations, driven by the group's own carry-in.

The adder has no clock and no reset. Its outputs follow its inputs within the same cycle, so a surrounding datapath can register it as it needs. The group width and the group count are parameters, and the default gives 16 bits.

Top module: `cla16_adder`

## Requirements
- R1: `sum_o` equals the low 16 bits of `op_a + op_b + carry_in`, treating both operands as unsigned.
- R2: `carry_out` equals bit 16 of the unsigned sum `op_a + op_b + carry_in`.
- R3: When every bit position has exactly one operand bit set (`op_a ^ op_b` is all ones) and `carry_in` is 1, the carry passes through all 16 positions: `sum_o` is 0x0000 and `carry_out` is 1. With `carry_in` 0 the same operands give `sum_o` = 0xFFFF and `carry_out` = 0.
- R4: A carry created in one group reaches every higher group whose bits all pass it on. For example, bit 0 created by both operands, with `op_a ^ op_b` = 0xFFFE and `carry_in` 0, gives `sum_o` = 0x0000 and `carry_out` = 1.
- R5: With both operands zero, `sum_o` equals `carry_in` in bit 0 and zero elsewhere, and `carry_out` is 0.
- R6: With both operands 0xFFFF, `sum_o` is 0xFFFE plus `carry_in`, and `carry_out` is 1.
- R7: The carry into group k (bit 4k) is 1 exactly when the bits below 4k overflow. So every 8-bit window of operand bits, swept through all values, gives the correct sum across group boundaries.
- R8: The outputs depend only on the present inputs. The same inputs always give the same result, whatever was applied before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 16 | First addend |
| op_b | input | 16 | Second addend |
| carry_in | input | 1 | Carry into bit 0 |
| sum_o | output | 16 | Low 16 bits of the sum |
| carry_out | output | 1 | Carry out of bit 15 |

## Verification
The embedded checks assume that the operands and the carry-in carry known 0/1 values. Each check is skipped while any input is unknown, so the undriven period before the first stimulus never trips one. The bench drives every input to a defined value before the first sample and never releases them. It changes them only between sampling points, so the combinational outputs have settled when they are read.

// File: rtl/cla_pkg.sv
package cla_pkg;

    // Width of one lookahead group and how many groups form the word.
    localparam int GRP_W   = 4;
    localparam int GRP_CNT = 4;
    localparam int WORD_W  = GRP_W * GRP_CNT;

    // Create / pass pair that a group exports to the upper lookahead.
    typedef struct packed {
        logic pass;
        logic make;
    } grp_pg_t;

endpackage

// File: rtl/cla_lookahead.sv
// Expanded sum-of-products carry network over N positions.
// c_o[j+1] = OR over k<=j of (g[k] & p[k+1..j])  OR  (p[0..j] & cin).
module cla_lookahead #(
    parameter int N = 4
) (
    input  logic [N-1:0] g_i,
    input  logic [N-1:0] p_i,
    input  logic         cin_i,
    output logic [N:0]   c_o,
    output logic         grp_g_o,
    output logic         grp_p_o
);

    always_comb begin
        logic acc;
        logic term;
        c_o[0] = cin_i;
        for (int j = 0; j < N; j++) begin
            term = cin_i;
            for (int k = 0; k <= j; k++) term = term & p_i[k];
            acc = term;
            for (int k = 0; k <= j; k++) begin
                term = g_i[k];
                for (int m = k + 1; m <= j; m++) term = term & p_i[m];
                acc = acc | term;
            end
            c_o[j+1] = acc;
        end
    end

    always_comb begin
        logic accg;
        logic t;
        accg = 1'b0;
        for (int k = 0; k < N; k++) begin
            t = g_i[k];
            for (int m = k + 1; m < N; m++) t = t & p_i[m];
            accg = accg | t;
        end
        grp_g_o = accg;
        grp_p_o = &p_i;
    end

    // R2: whatever the carry-in, a set group create flag forces the top carry.
    always_comb begin
        if (!$isunknown({g_i, p_i, cin_i}))
            p_grp_make_top_r2: assert (!grp_g_o || c_o[N])
                else $error("group create without top carry");
    end

endmodule

// File: rtl/cla_group.sv
// One lookahead group: bit create/pass terms, local carries, sum bits.
module cla_group
    import cla_pkg::*;
#(
    parameter int W = GRP_W
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output grp_pg_t      pg_o
);

    logic [W-1:0] bit_g;
    logic [W-1:0] bit_p;
    logic [W:0]   car;
    logic         gg;
    logic         gp;

    assign bit_g = a_i & b_i;
    assign bit_p = a_i | b_i;

    cla_lookahead #(.N(W)) u_la (
        .g_i     (bit_g),
        .p_i     (bit_p),
        .cin_i   (cin_i),
        .c_o     (car),
        .grp_g_o (gg),
        .grp_p_o (gp)
    );

    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_sum
            assign sum_o[i] = a_i[i] ^ b_i[i] ^ car[i];
        end
    endgenerate

    assign pg_o.pass = gp;
    assign pg_o.make = gg;

    // R3: the group passes a carry only if every bit has an operand bit set.
    always_comb begin
        if (!$isunknown({a_i, b_i, cin_i}))
            p_grp_pass_r3: assert (!pg_o.pass || ((a_i | b_i) == {W{1'b1}}))
                else $error("group pass with an empty position");
    end

    // R7: a group create flag needs at least one bit with both operands set.
    always_comb begin
        if (!$isunknown({a_i, b_i, cin_i}))
            p_grp_make_r7: assert (!pg_o.make || ((a_i & b_i) != '0))
                else $error("group create with no bit create");
    end

endmodule

// File: rtl/cla16_adder.sv
module cla16_adder
    import cla_pkg::*;
#(
    parameter int GW = GRP_W,
    parameter int GN = GRP_CNT
) (
    input  logic [GW*GN-1:0] op_a,
    input  logic [GW*GN-1:0] op_b,
    input  logic             carry_in,
    output logic [GW*GN-1:0] sum_o,
    output logic             carry_out
);

    localparam int W = GW * GN;

    grp_pg_t        grp [GN];
    logic [GN-1:0]  top_g;
    logic [GN-1:0]  top_p;
    logic [GN:0]    grp_c;
    logic           unused_g;
    logic           unused_p;

    genvar k;
    generate
        for (k = 0; k < GN; k++) begin : g_grp
            cla_group #(.W(GW)) u_grp (
                .a_i   (op_a[k*GW +: GW]),
                .b_i   (op_b[k*GW +: GW]),
                .cin_i (grp_c[k]),
                .sum_o (sum_o[k*GW +: GW]),
                .pg_o  (grp[k])
            );
            assign top_g[k] = grp[k].make;
            assign top_p[k] = grp[k].pass;
        end
    endgenerate

    // Second lookahead level across the groups.
    cla_lookahead #(.N(GN)) u_top (
        .g_i     (top_g),
        .p_i     (top_p),
        .cin_i   (carry_in),
        .c_o     (grp_c),
        .grp_g_o (unused_g),
        .grp_p_o (unused_p)
    );

    assign carry_out = grp_c[GN];

    // R1 and R2: the result matches an arithmetic reference.
    always_comb begin
        logic [W:0] ref_sum;
        ref_sum = {1'b0, op_a} + {1'b0, op_b} + {{W{1'b0}}, carry_in};
        if (!$isunknown({op_a, op_b, carry_in})) begin
            p_sum_r1: assert (sum_o == ref_sum[W-1:0])
                else $error("sum mismatch");
            p_cout_r2: assert (carry_out == ref_sum[W])
                else $error("carry-out mismatch");
        end
    end

endmodule

// File: tb/cla16_adder_tb.sv
module cla16_adder_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] a;
    logic [15:0] b;
    logic        ci;
    logic [15:0] s;
    logic        co;
    int          total = 0;
    int          bad   = 0;
    int          cyc   = 0;
    bit          done  = 1'b0;

    always #2.5 clk = ~clk;

    cla16_adder u_dut (
        .op_a      (a),
        .op_b      (b),
        .carry_in  (ci),
        .sum_o     (s),
        .carry_out (co)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic apply(input logic [15:0] xa, input logic [15:0] xb, input logic xc);
        a = xa; b = xb; ci = xc;
        #1;
    endtask

    task automatic expect_val(input string req, input logic [15:0] es, input logic ec);
        total = total + 1;
        if (s !== es || co !== ec) begin
            bad = bad + 1;
            $display("FAIL %s: a=%h b=%h cin=%b actual=%b_%h expected=%b_%h",
                     req, a, b, ci, co, s, ec, es);
        end
    endtask

    task automatic check_ref(input string req);
        logic [16:0] r;
        r = {1'b0, a} + {1'b0, b} + {16'd0, ci};
        expect_val(req, r[15:0], r[16]);
    endtask

    task automatic t_zero();    // R5 and initial state
        apply(16'h0000, 16'h0000, 1'b0); expect_val("R5", 16'h0000, 1'b0);
        apply(16'h0000, 16'h0000, 1'b1); expect_val("R5", 16'h0001, 1'b0);
    endtask

    task automatic t_pass_chain();   // R3
        apply(16'hFFFF, 16'h0000, 1'b1); expect_val("R3", 16'h0000, 1'b1);
        apply(16'hA5C3, 16'h5A3C, 1'b1); expect_val("R3", 16'h0000, 1'b1);
        apply(16'hA5C3, 16'h5A3C, 1'b0); expect_val("R3", 16'hFFFF, 1'b0);
    endtask

    task automatic t_make_chain();   // R4
        apply(16'hFFFF, 16'h0001, 1'b0); expect_val("R4", 16'h0000, 1'b1);
        apply(16'h00FF, 16'h0011, 1'b0); expect_val("R4", 16'h0110, 1'b0);
        apply(16'h0FF8, 16'h0008, 1'b0); expect_val("R4", 16'h1000, 1'b0);
    endtask

    task automatic t_all_ones();     // R6
        apply(16'hFFFF, 16'hFFFF, 1'b0); expect_val("R6", 16'hFFFE, 1'b1);
        apply(16'hFFFF, 16'hFFFF, 1'b1); expect_val("R6", 16'hFFFF, 1'b1);
    endtask

    task automatic t_window(input int sh, input logic [15:0] base_a, input logic [15:0] base_b); // R7
        for (int x = 0; x < 256; x++) begin
            for (int y = 0; y < 256; y++) begin
                logic [15:0] xa;
                logic [15:0] xb;
                xa = base_a & ~(16'h00FF << sh);
                xb = base_b & ~(16'h00FF << sh);
                xa = xa | (16'(x) << sh);
                xb = xb | (16'(y) << sh);
                apply(xa, xb, 1'((x ^ y) & 1) ^ 1'(x[7]));
                check_ref("R7");
            end
        end
    endtask

    task automatic t_random();       // R1, R2
        for (int n = 0; n < 4000; n++) begin
            apply(16'($urandom), 16'($urandom), 1'($urandom));
            check_ref("R1");
        end
        for (int n = 0; n < 64; n++) begin
            apply(16'(1) << (n % 16), 16'hFFFF, 1'($urandom));
            check_ref("R2");
        end
    endtask

    task automatic t_history();      // R8
        apply(16'h1234, 16'h4321, 1'b1); expect_val("R8", 16'h5556, 1'b0);
        apply(16'hFFFF, 16'hFFFF, 1'b1);
        apply(16'h1234, 16'h4321, 1'b1); expect_val("R8", 16'h5556, 1'b0);
    endtask

    initial begin
        a = '0; b = '0; ci = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        t_zero();
        t_pass_chain();
        t_make_chain();
        t_all_ones();
        t_history();
        t_window(0, 16'h0000, 16'h0000);
        t_window(4, 16'hF00F, 16'h0FF0);
        t_random();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule